// File: doc/BRIEF.md
# Cross-Domain Error Counter Register

This block keeps a pair of 8-bit fault tallies for a CAN controller: one for transmit errors and one for receive errors. Both counters live in the protocol clock domain, where the protocol engine moves them with single-cycle increment, decrement and clear pulses. A CPU on a separate bus clock sees the two counters as one 16-bit register. Every read returns the latest value that has been carried across to the bus side. The read path carries the counters across as a whole-word snapshot, so a read never returns a mix of old and new bits.

While the freeze input is high, the CPU may overwrite both counters. The write is indirect. The bus side first stores the value in a holding register and then sends it to the protocol domain with a toggle-based request/acknowledge exchange. The block has no done flag. Software confirms that the write took effect by reading the register until it returns the written value. If a second write arrives before the first exchange has finished, the second write replaces the held value and is sent once the first exchange has completed.

Top module: `errcnt_cdc_reg`

## Requirements
- R1: After reset both counters are 0, and the bus-side read word is 0x0000.
- R2: An increment pulse adds one to its counter. A counter at 255 stays at 255.
- R3: A decrement pulse subtracts one from its counter. A counter at 0 stays at 0.
- R4: A clear pulse sets its counter to 0, even when an increment or decrement pulse arrives in the same cycle.
- R5: Increment and decrement pulses on the same counter in the same cycle leave that counter unchanged.
- R6: A bus write while freeze is low has no effect. Neither counter changes, and the read word keeps its value.
- R7: A bus write while freeze is high loads both counters after the handshake delay: the transmit counter from data bits [15:8] and the receive counter from bits [7:0]. The read word then returns the written value.
- R8: In the protocol cycle in which a CPU-written value is applied, that value takes priority over clear, increment and decrement pulses. Those pulses take effect again from the next cycle.
- R9: When several writes in freeze mode arrive while a transfer is still in flight, the counters end up holding the value of the last write.
- R10: The read word is always a pair of counter values that existed together in one protocol cycle. It uses the same layout: transmit counter in [15:8], receive counter in [7:0]. After the counters stop changing, the read word catches up with them within a bounded number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | CPU bus clock |
| bus_rst_n | input | 1 | Synchronous active-low reset, bus domain |
| freeze_i | input | 1 | Freeze mode; CPU writes are accepted only while high |
| wr_en_i | input | 1 | Single-cycle CPU write strobe |
| wr_data_i | input | 16 | Write data: transmit value in [15:8], receive value in [7:0] |
| rd_data_o | output | 16 | Read word: transmit counter in [15:8], receive counter in [7:0] |
| can_clk | input | 1 | Protocol engine clock |
| can_rst_n | input | 1 | Synchronous active-low reset, protocol domain |
| tx_inc_i | input | 1 | Transmit counter increment pulse |
| tx_dec_i | input | 1 | Transmit counter decrement pulse |
| tx_clr_i | input | 1 | Transmit counter clear pulse |
| rx_inc_i | input | 1 | Receive counter increment pulse |
| rx_dec_i | input | 1 | Receive counter decrement pulse |
| rx_clr_i | input | 1 | Receive counter clear pulse |
| tx_cnt_o | output | 8 | Live transmit counter, protocol domain |
| rx_cnt_o | output | 8 | Live receive counter, protocol domain |

## Verification
The hardest case to reach is the single protocol cycle in which a CPU load and a competing counter pulse coincide. The load lands on a cycle that depends on the synchroniser delay and on the phase between the two clocks. The bench therefore holds the transmit clear input high for the whole transfer and counts the protocol cycles in which the loaded value is visible. With that stimulus, the load must appear for exactly one cycle before the clear takes hold again. Torn reads are hunted for by watching the read word on every bus cycle during long increment and decrement sweeps and checking that it only ever moves in one direction.

// File: rtl/errcnt_pkg.sv
// Package: shared widths and types for the cross-domain error counter register.
// Assumes two counters of equal width packed side by side, transmit counter in the upper half.
package errcnt_pkg;
    localparam int CNT_W   = 8;
    localparam int NUM_CNT = 2;
    localparam int REG_W   = CNT_W * NUM_CNT;
    localparam int IDX_TX  = 1;
    localparam int IDX_RX  = 0;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [REG_W-1:0] reg_t;
endpackage

// File: rtl/errcnt_sync.sv
// Module: two-flop synchroniser for level or toggle signals.
// Assumes each bit is independent (used only for single-bit toggles here).
module errcnt_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] s1_q;
    logic [W-1:0] s2_q;

    // Purpose: two register stages to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d_i;
            s2_q <= s1_q;
        end
    end

    assign q_o = s2_q;
endmodule

// File: rtl/errcnt_counter.sv
// Module: one saturating error counter in the protocol domain.
// Priority order: CPU load, clear, then increment/decrement. Opposing inc/dec in one cycle hold the value.
// Assumes load_val_i is stable whenever load_i is high.
module errcnt_counter
    import errcnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  cnt_t load_val_i,
    input  logic inc_i,
    input  logic dec_i,
    input  logic clr_i,
    output cnt_t cnt_o
);
    localparam cnt_t CNT_MAX = '1;
    localparam cnt_t CNT_MIN = '0;

    cnt_t cnt_q;

    // Purpose: apply load, clear or a saturating single-step update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_MIN;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (clr_i) begin
            cnt_q <= CNT_MIN;
        end else if (inc_i && !dec_i && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (dec_i && !inc_i && cnt_q != CNT_MIN) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    assert_sat_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && inc_i && !dec_i && !clr_i && !load_i) |=> (cnt_q == CNT_MAX));
    assert_sat_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MIN && dec_i && !inc_i && !clr_i && !load_i) |=> (cnt_q == CNT_MIN));
    assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !load_i) |=> (cnt_q == CNT_MIN));
    assert_opposed_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && dec_i && !clr_i && !load_i) |=> $stable(cnt_q));
    assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/errcnt_bus_side.sv
// Module: bus-domain half of the register.
// Holds the auxiliary write register and launches request toggles to the protocol domain.
// Captures snapshots offered by the protocol domain into the read word.
// Assumes ack_tgl_i and snap_tgl_i come from the protocol domain and snap_i is stable while its toggle is pending.
module errcnt_bus_side
    import errcnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic freeze_i,
    input  logic wr_en_i,
    input  reg_t wr_data_i,
    input  logic ack_tgl_i,
    output logic req_tgl_o,
    output reg_t xfer_o,
    input  logic snap_tgl_i,
    input  reg_t snap_i,
    output logic snap_ack_o,
    output reg_t rd_data_o
);
    reg_t aux_q;
    reg_t xfer_q;
    reg_t rd_q;
    logic pend_q;
    logic req_tgl_q;
    logic seen_q;
    logic ack_s;
    logic snap_s;
    logic busy;
    logic wr_ok;
    logic launch;

    errcnt_sync #(.W(1)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ack_tgl_i),
        .q_o   (ack_s)
    );

    errcnt_sync #(.W(1)) u_snap_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (snap_tgl_i),
        .q_o   (snap_s)
    );

    assign busy   = (req_tgl_q != ack_s);
    assign wr_ok  = wr_en_i && freeze_i;
    assign launch = pend_q && !busy;

    // Purpose: capture accepted CPU writes in the auxiliary register and mark them pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aux_q  <= '0;
            pend_q <= 1'b0;
        end else if (wr_ok) begin
            aux_q  <= wr_data_i;
            pend_q <= 1'b1;
        end else if (launch) begin
            pend_q <= 1'b0;
        end
    end

    // Purpose: move the pending value into the transfer register and toggle the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_q    <= '0;
            req_tgl_q <= 1'b0;
        end else if (launch) begin
            xfer_q    <= aux_q;
            req_tgl_q <= ~req_tgl_q;
        end
    end

    // Purpose: latch a fresh snapshot when its toggle arrives and return the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= '0;
            seen_q <= 1'b0;
        end else if (snap_s != seen_q) begin
            rd_q   <= snap_i;
            seen_q <= snap_s;
        end
    end

    assign req_tgl_o  = req_tgl_q;
    assign xfer_o     = xfer_q;
    assign snap_ack_o = seen_q;
    assign rd_data_o  = rd_q;

    assert_ignored_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !freeze_i && !launch) |=> ($stable(aux_q) && $stable(pend_q)));
    assert_write_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> pend_q);
    assert_xfer_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(xfer_q) && $stable(req_tgl_q)));
    assert_read_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_s == seen_q) |=> $stable(rd_q));
endmodule

// File: rtl/errcnt_can_side.sv
// Module: protocol-domain half of the register.
// Detects write request toggles, issues a one-cycle load, acknowledges it.
// Offers whole-word counter snapshots to the bus domain.
// Assumes the bus side holds xfer data stable between request toggle and acknowledge.
module errcnt_can_side
    import errcnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_tgl_i,
    output logic ack_tgl_o,
    output logic load_o,
    input  reg_t cnt_i,
    input  logic snap_ack_i,
    output logic snap_tgl_o,
    output reg_t snap_o
);
    logic req_s;
    logic ack_q;
    logic snap_ack_s;
    logic snap_tgl_q;
    reg_t snap_q;
    logic load;
    logic snap_idle;

    errcnt_sync #(.W(1)) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (req_tgl_i),
        .q_o   (req_s)
    );

    errcnt_sync #(.W(1)) u_sack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (snap_ack_i),
        .q_o   (snap_ack_s)
    );

    assign load      = (req_s != ack_q);
    assign snap_idle = (snap_ack_s == snap_tgl_q);

    // Purpose: follow the synchronised request so each toggle yields exactly one load cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
        end else if (load) begin
            ack_q <= req_s;
        end
    end

    // Purpose: take a new snapshot only after the previous one was acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q     <= '0;
            snap_tgl_q <= 1'b0;
        end else if (snap_idle) begin
            snap_q     <= cnt_i;
            snap_tgl_q <= ~snap_tgl_q;
        end
    end

    assign ack_tgl_o  = ack_q;
    assign load_o     = load;
    assign snap_tgl_o = snap_tgl_q;
    assign snap_o     = snap_q;

    assert_single_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);
    assert_snap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_idle |=> ($stable(snap_q) && $stable(snap_tgl_q)));
endmodule

// File: rtl/errcnt_cdc_reg.sv
// Module: top of the cross-domain error counter register.
// Two saturating counters in the protocol domain, a freeze-gated indirect CPU write path, and a snapshot read path.
// Assumes both resets are applied together long enough to clear both domains.
module errcnt_cdc_reg
    import errcnt_pkg::*;
(
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              freeze_i,
    input  logic              wr_en_i,
    input  logic [REG_W-1:0]  wr_data_i,
    output logic [REG_W-1:0]  rd_data_o,
    input  logic              can_clk,
    input  logic              can_rst_n,
    input  logic              tx_inc_i,
    input  logic              tx_dec_i,
    input  logic              tx_clr_i,
    input  logic              rx_inc_i,
    input  logic              rx_dec_i,
    input  logic              rx_clr_i,
    output logic [CNT_W-1:0]  tx_cnt_o,
    output logic [CNT_W-1:0]  rx_cnt_o
);
    logic req_tgl;
    logic ack_tgl;
    logic snap_tgl;
    logic snap_ack;
    logic load;
    reg_t xfer;
    reg_t snap;
    reg_t cnt_all;
    logic [NUM_CNT-1:0] inc_v;
    logic [NUM_CNT-1:0] dec_v;
    logic [NUM_CNT-1:0] clr_v;

    assign inc_v[IDX_TX] = tx_inc_i;
    assign inc_v[IDX_RX] = rx_inc_i;
    assign dec_v[IDX_TX] = tx_dec_i;
    assign dec_v[IDX_RX] = rx_dec_i;
    assign clr_v[IDX_TX] = tx_clr_i;
    assign clr_v[IDX_RX] = rx_clr_i;

    errcnt_bus_side u_bus (
        .clk        (bus_clk),
        .rst_n      (bus_rst_n),
        .freeze_i   (freeze_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .ack_tgl_i  (ack_tgl),
        .req_tgl_o  (req_tgl),
        .xfer_o     (xfer),
        .snap_tgl_i (snap_tgl),
        .snap_i     (snap),
        .snap_ack_o (snap_ack),
        .rd_data_o  (rd_data_o)
    );

    errcnt_can_side u_can (
        .clk        (can_clk),
        .rst_n      (can_rst_n),
        .req_tgl_i  (req_tgl),
        .ack_tgl_o  (ack_tgl),
        .load_o     (load),
        .cnt_i      (cnt_all),
        .snap_ack_i (snap_ack),
        .snap_tgl_o (snap_tgl),
        .snap_o     (snap)
    );

    // One counter per field; field i occupies bits [i*CNT_W +: CNT_W].
    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
        cnt_t cnt_w;
        errcnt_counter u_counter (
            .clk        (can_clk),
            .rst_n      (can_rst_n),
            .load_i     (load),
            .load_val_i (xfer[gi*CNT_W +: CNT_W]),
            .inc_i      (inc_v[gi]),
            .dec_i      (dec_v[gi]),
            .clr_i      (clr_v[gi]),
            .cnt_o      (cnt_w)
        );
        assign cnt_all[gi*CNT_W +: CNT_W] = cnt_w;
    end

    assign tx_cnt_o = cnt_all[IDX_TX*CNT_W +: CNT_W];
    assign rx_cnt_o = cnt_all[IDX_RX*CNT_W +: CNT_W];
endmodule

// File: tb/errcnt_cdc_reg_tb.sv
// Bench: sweeps counter steps, freeze-mode writes and collisions; expected values computed arithmetically.
module errcnt_cdc_reg_tb;
    logic        bus_clk = 1'b0;
    logic        can_clk = 1'b0;
    logic        bus_rst_n = 1'b0;
    logic        can_rst_n = 1'b0;
    logic        freeze_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] rd_data_o;
    logic        tx_inc_i = 0, tx_dec_i = 0, tx_clr_i = 0;
    logic        rx_inc_i = 0, rx_dec_i = 0, rx_clr_i = 0;
    logic [7:0]  tx_cnt_o;
    logic [7:0]  rx_cnt_o;

    int nvec = 0;
    int nfail = 0;
    bit done = 0;

    bit        mon_en = 0;
    bit        mon_up = 1;
    logic [7:0] mon_rx = '0;
    logic [7:0] mon_prev = '0;

    always #2.5 bus_clk = ~bus_clk;
    always #3.5 can_clk = ~can_clk;

    errcnt_cdc_reg u_dut (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .freeze_i(freeze_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
        .can_clk(can_clk), .can_rst_n(can_rst_n),
        .tx_inc_i(tx_inc_i), .tx_dec_i(tx_dec_i), .tx_clr_i(tx_clr_i),
        .rx_inc_i(rx_inc_i), .rx_dec_i(rx_dec_i), .rx_clr_i(rx_clr_i),
        .tx_cnt_o(tx_cnt_o), .rx_cnt_o(rx_cnt_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // p = {tx_inc, tx_dec, tx_clr, rx_inc, rx_dec, rx_clr}; one protocol cycle of pulses, then sample.
    task automatic can_step(input logic [5:0] p);
        @(negedge can_clk);
        {tx_inc_i, tx_dec_i, tx_clr_i, rx_inc_i, rx_dec_i, rx_clr_i} = p;
        @(negedge can_clk);
        {tx_inc_i, tx_dec_i, tx_clr_i, rx_inc_i, rx_dec_i, rx_clr_i} = '0;
    endtask

    task automatic cpu_write(input logic frz, input logic [15:0] d);
        @(negedge bus_clk);
        freeze_i  = frz;
        wr_en_i   = 1'b1;
        wr_data_i = d;
        @(negedge bus_clk);
        wr_en_i   = 1'b0;
    endtask

    task automatic settle();
        repeat (80) @(negedge bus_clk);
    endtask

    // Read-word monitor: tx field moves monotonically, rx field constant (R10 no torn reads).
    always @(negedge bus_clk) begin
        if (mon_en) begin
            nvec++;
            if ((mon_up ? (rd_data_o[15:8] < mon_prev) : (rd_data_o[15:8] > mon_prev))
                || rd_data_o[7:0] !== mon_rx) begin
                nfail++;
                $display("FAIL R10 actual=%h expected tx %s %h, rx=%h", rd_data_o,
                         mon_up ? ">=" : "<=", mon_prev, mon_rx);
            end
            mon_prev = rd_data_o[15:8];
        end
    end

    initial begin
        repeat (150000) @(posedge bus_clk);
        if (!done) begin
            nvec++;
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        int hits;
        repeat (6) @(negedge can_clk);
        bus_rst_n = 1'b1;
        can_rst_n = 1'b1;
        repeat (4) @(negedge bus_clk);
        // R1 reset state
        chk("R1", rd_data_o, 16'h0000);
        chk("R1", {8'h00, tx_cnt_o}, 16'h0000);
        chk("R1", {8'h00, rx_cnt_o}, 16'h0000);

        // R2 increment sweep past saturation, monitored read path
        mon_up = 1; mon_rx = 8'h00; mon_prev = 8'h00; mon_en = 1;
        for (int n = 1; n <= 260; n++) begin
            can_step(6'b100000);
            chk("R2", {8'h00, tx_cnt_o}, 16'((n > 255) ? 255 : n));
        end
        settle();
        mon_en = 0;
        chk("R10", rd_data_o, 16'hFF00);

        // R3 decrement sweep past zero
        mon_up = 0; mon_prev = 8'hFF; mon_en = 1;
        for (int n = 1; n <= 260; n++) begin
            can_step(6'b010000);
            chk("R3", {8'h00, tx_cnt_o}, 16'((n > 255) ? 0 : 255 - n));
        end
        settle();
        mon_en = 0;
        chk("R10", rd_data_o, 16'h0000);
        can_step(6'b000010);
        chk("R3", {8'h00, rx_cnt_o}, 16'h0000);

        // R5 opposing pulses hold
        for (int n = 0; n < 5; n++) can_step(6'b100000);
        can_step(6'b110000);
        chk("R5", {8'h00, tx_cnt_o}, 16'h0005);
        can_step(6'b000110);
        chk("R5", {8'h00, rx_cnt_o}, 16'h0000);

        // R4 clear beats increment / decrement
        can_step(6'b101000);
        chk("R4", {8'h00, tx_cnt_o}, 16'h0000);
        for (int n = 0; n < 3; n++) can_step(6'b000100);
        can_step(6'b000011);
        chk("R4", {8'h00, rx_cnt_o}, 16'h0000);

        // R6 write outside freeze is ignored
        for (int n = 0; n < 3; n++) can_step(6'b100000);
        cpu_write(1'b0, 16'hABCD);
        settle();
        chk("R6", rd_data_o, 16'h0300);
        chk("R6", {tx_cnt_o, rx_cnt_o}, 16'h0300);

        // R7 freeze-mode write sweep
        for (int k = 0; k < 16; k++) begin
            logic [15:0] v;
            v = {8'(k * 17), 8'(8'hFF - k * 13)};
            cpu_write(1'b1, v);
            settle();
            chk("R7", rd_data_o, v);
            chk("R7", {8'h00, tx_cnt_o}, {8'h00, v[15:8]});
            chk("R7", {8'h00, rx_cnt_o}, {8'h00, v[7:0]});
        end

        // R9 back-to-back writes while a transfer is in flight
        @(negedge bus_clk);
        freeze_i = 1'b1; wr_en_i = 1'b1; wr_data_i = 16'h1122;
        @(negedge bus_clk); wr_data_i = 16'h3344;
        @(negedge bus_clk); wr_data_i = 16'h5566;
        @(negedge bus_clk); wr_en_i = 1'b0;
        settle();
        chk("R9", rd_data_o, 16'h5566);
        chk("R9", {tx_cnt_o, rx_cnt_o}, 16'h5566);

        // R8 load wins over a held clear for exactly one protocol cycle
        @(negedge can_clk);
        tx_clr_i = 1'b1;
        repeat (3) @(negedge can_clk);
        hits = 0;
        fork
            cpu_write(1'b1, 16'h7710);
            begin
                for (int c = 0; c < 120; c++) begin
                    @(negedge can_clk);
                    if (tx_cnt_o == 8'h77) hits++;
                end
            end
        join
        chk("R8", 16'(hits), 16'd1);
        chk("R8", {tx_cnt_o, rx_cnt_o}, 16'h0010);
        @(negedge can_clk);
        tx_clr_i = 1'b0;
        settle();
        chk("R10", rd_data_o, 16'h0010);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule